// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received frames into a circular buffer that lives in byte-addressed local memory. The memory is divided into 256-byte pages. Three page-number inputs bound and guard the ring: the first page, the page just past the last one, and the page the host has read up to. The block itself owns the page where the next frame will land. A frame begins with a one-cycle start strobe that carries the frame length. The payload bytes then arrive on a valid-qualified byte stream. The block writes the bytes out through a single-cycle synchronous memory write port.

On each start strobe the block decides whether the ring has room. If the controller is stopped or the ring is too full, the frame is discarded. Otherwise the block performs these steps:

- It streams the payload into memory four bytes past the start of the current page, wrapping from the end of the ring back to its first page.
- It pads short frames with zeros.
- It writes a four-byte descriptor at the head of the current page.
- It advances the current page past the stored frame, rounded up to a whole page.
- It pulses a receive-done interrupt.

The host may load the current page while the block is idle.

Top module: `rx_ring_writer`

## Requirements
- R1: A start strobe sampled while `busy` is low, the controller not stopped and the ring not full accepts the frame. `busy` is high from the next cycle until the current page is updated. `in_rdy` is high exactly while payload bytes are being taken. A byte is consumed on a rising edge where both `byte_valid` and `in_rdy` are high.
- R2: A start strobe sampled while `stopped` is high is discarded. No memory write happens, `busy` stays low, and `cur_pg` and `irq_rx` do not change.
- R3: The free space is computed in pages, with a page taken as 256 bytes. When `cur_pg` ≤ `bnd_pg`, free = `bnd_pg` − `cur_pg`. Otherwise free = (`stop_pg` − `start_pg`) − (`cur_pg` − `bnd_pg`). A frame is discarded, exactly as in R2, when free × 256 is below 1518 bytes. For example, five free pages (1280 bytes) and `cur_pg` = `bnd_pg` both discard the frame, while six free pages (1536 bytes) accept it.
- R4: Payload byte i is written to byte address `cur_pg`×256 + 4 + i, in arrival order, with one memory write per consumed byte.
- R5: When the payload write address would reach `stop_pg`×256, the next byte goes to `start_pg`×256 instead. This can happen partway through a frame.
- R6: A frame shorter than 60 bytes is followed in memory by zero bytes up to a stored payload of 60 bytes, at the addresses R4 and R5 give.
- R7: After the payload, four descriptor bytes are written to `cur_pg`×256 + 0, 1, 2 and 3, in that order. Byte 0 is the status: 0x01, with bit 5 also set when bit 0 of the first payload byte is 1. Byte 1 is the next page. Bytes 2 and 3 are the stored length (payload as padded, plus 4), low byte first.
- R8: The next page is `cur_pg` + floor((stored length + 4 + 255) / 256). If that reaches `stop_pg`, (`stop_pg` − `start_pg`) is subtracted from it. On the edge that writes the last descriptor byte, `cur_pg` takes the next page and `busy` falls. `irq_rx` is high for exactly the one following cycle.
- R9: `cur_wr` loads `cur_wdata` into `cur_pg` on the next edge only while `busy` is low. While a frame is in progress it has no effect.
- R10: After reset, `busy`, `in_rdy`, `mem_we` and `irq_rx` are low and `cur_pg` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stopped | input | 1 | Controller stopped; frames are discarded |
| start_pg | input | PG_W | First page of the ring |
| stop_pg | input | PG_W | Page just past the ring |
| bnd_pg | input | PG_W | Host read boundary page |
| cur_wr | input | 1 | Host load strobe for the current page |
| cur_wdata | input | PG_W | Value for the host load |
| frm_start | input | 1 | Frame start strobe |
| frm_len | input | LEN_W | Frame length in bytes, valid with `frm_start` |
| byte_valid | input | 1 | Payload byte valid |
| byte_data | input | 8 | Payload byte |
| in_rdy | output | 1 | Payload bytes are being taken |
| busy | output | 1 | A frame is being stored |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PG_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | PG_W | Current page |
| irq_rx | output | 1 | Receive-done pulse |

## Verification
The bench builds the block with its default parameters: 8-bit page numbers, 11-bit lengths, a 60-byte minimum and a 1518-byte room threshold. The ring is placed at pages 0x40 to 0x4F, which is only 16 pages. With such a small ring, randomly sized frames repeatedly wrap their payload across the ring's end. Their next-page sums also regularly cross the stop page. Both free-space formulas can be pushed onto their five-page and six-page edges by choosing the boundary page directly.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PG_W    = 8,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 60,
  parameter int ROOM    = 1518,
  parameter int HDR     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopped,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [PG_W-1:0]  bnd_pg,
  input  logic             cur_wr,
  input  logic [PG_W-1:0]  cur_wdata,
  input  logic             frm_start,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             in_rdy,
  output logic             busy,
  output logic             mem_we,
  output logic [PG_W+7:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [PG_W-1:0]  cur_pg,
  output logic             irq_rx
);
  localparam int AW = PG_W + 8;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAD, S_HDR} st_t;
  st_t st;

  logic [LEN_W-1:0] len_q, cnt;
  logic [LEN_W:0]   tot_q;
  logic [AW-1:0]    waddr;
  logic [PG_W-1:0]  nxt_q;
  logic [1:0]       hidx;
  logic             mc;

  // sizing of the incoming frame
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W:0]   tot_len;
  logic [LEN_W+1:0] span;
  logic [PG_W:0]    nxt_raw, ring, free_pg;
  logic [PG_W-1:0]  nxt_pg;
  logic             full, accept;

  assign eff_len = (frm_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : frm_len;
  assign tot_len = {1'b0, eff_len} + (LEN_W+1)'(HDR);
  assign span    = {1'b0, tot_len} + (LEN_W+2)'(HDR + 255);
  assign nxt_raw = {1'b0, cur_pg} + (PG_W+1)'(span >> 8);
  assign ring    = {1'b0, stop_pg} - {1'b0, start_pg};
  assign nxt_pg  = PG_W'((nxt_raw >= {1'b0, stop_pg}) ? nxt_raw - ring : nxt_raw);
  assign free_pg = (cur_pg <= bnd_pg) ? {1'b0, bnd_pg} - {1'b0, cur_pg}
                                      : ring - ({1'b0, cur_pg} - {1'b0, bnd_pg});
  assign full    = {free_pg, 8'h00} < (PG_W+9)'(ROOM);
  assign accept  = frm_start && (st == S_IDLE) && !stopped && !full;

  // payload address with ring wrap
  logic [AW-1:0] waddr_inc, waddr_nx;
  assign waddr_inc = waddr + AW'(1);
  assign waddr_nx  = (waddr_inc == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : waddr_inc;

  logic [7:0] hdr_byte;
  always_comb begin
    case (hidx)
      2'd0:    hdr_byte = mc ? 8'h21 : 8'h01;
      2'd1:    hdr_byte = 8'(nxt_q);
      2'd2:    hdr_byte = tot_q[7:0];
      default: hdr_byte = 8'(tot_q >> 8);
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign in_rdy    = (st == S_DATA);
  assign mem_we    = (in_rdy && byte_valid) || st == S_PAD || st == S_HDR;
  assign mem_addr  = (st == S_HDR) ? {cur_pg, 6'b0, hidx} : waddr;
  assign mem_wdata = (st == S_HDR) ? hdr_byte : (st == S_PAD) ? 8'h00 : byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; len_q <= '0; cnt <= '0; tot_q <= '0; waddr <= '0;
      nxt_q <= '0; hidx <= '0; mc <= 1'b0; cur_pg <= '0; irq_rx <= 1'b0;
    end else begin
      irq_rx <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            len_q <= frm_len;
            tot_q <= tot_len;
            nxt_q <= nxt_pg;
            waddr <= {cur_pg, 8'(HDR)};
            cnt   <= '0;
            mc    <= 1'b0;
            hidx  <= '0;
            st    <= (frm_len == '0) ? S_PAD : S_DATA;
          end else if (cur_wr) begin
            cur_pg <= cur_wdata;
          end
        end
        S_DATA: if (byte_valid) begin
          waddr <= waddr_nx;
          cnt   <= cnt + LEN_W'(1);
          if (cnt == '0) mc <= byte_data[0];
          if (cnt + LEN_W'(1) == len_q)
            st <= (len_q < LEN_W'(MIN_LEN)) ? S_PAD : S_HDR;
        end
        S_PAD: begin
          waddr <= waddr_nx;
          cnt   <= cnt + LEN_W'(1);
          if (cnt + LEN_W'(1) >= LEN_W'(MIN_LEN)) st <= S_HDR;
        end
        default: begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            cur_pg <= nxt_q;
            irq_rx <= 1'b1;
            st     <= S_IDLE;
          end
        end
      endcase
    end
  end

  p_accept_from_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_start));
  p_stopped_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !busy && stopped) |=> !busy);
  p_write_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && start_pg < stop_pg && cur_pg >= start_pg && cur_pg < stop_pg)
      |-> (mem_addr >= {start_pg, 8'h00} && mem_addr < {stop_pg, 8'h00}));
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);
  p_cur_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_pg) |-> (irq_rx || $past(cur_wr && !busy)));
endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  localparam int PG_W = 8;
  localparam int LEN_W = 11;
  localparam int RS = 8'h40;
  localparam int RE = 8'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stopped = 1'b0;
  logic [PG_W-1:0] start_pg = PG_W'(RS);
  logic [PG_W-1:0] stop_pg = PG_W'(RE);
  logic [PG_W-1:0] bnd_pg = '0;
  logic cur_wr = 1'b0;
  logic [PG_W-1:0] cur_wdata = '0;
  logic frm_start = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic in_rdy, busy, mem_we, irq_rx;
  logic [PG_W+7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [PG_W-1:0] cur_pg;

  always #4 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .start_pg(start_pg),
    .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_wr(cur_wr), .cur_wdata(cur_wdata),
    .frm_start(frm_start), .frm_len(frm_len), .byte_valid(byte_valid),
    .byte_data(byte_data), .in_rdy(in_rdy), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_pg(cur_pg), .irq_rx(irq_rx));

  int vec = 0;
  int errs = 0;
  logic [7:0] fb [0:1513];
  int exp_addr[$];
  int exp_data[$];
  string exp_tag[$];

  task automatic chk(bit ok, string tag, int act, int expv);
    vec++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R2/R3 unexpected memory write", int'(mem_addr), -1);
      end else begin
        int a;
        int d;
        string t;
        a = exp_addr.pop_front();
        d = exp_data.pop_front();
        t = exp_tag.pop_front();
        chk(int'(mem_addr) == a, {t, " address"}, int'(mem_addr), a);
        chk(int'(mem_wdata) == d, {t, " data"}, int'(mem_wdata), d);
      end
    end
  end

  function automatic int next_page(int cur, int len);
    int eff;
    int tot;
    int n;
    eff = (len < 60) ? 60 : len;
    tot = eff + 4;
    n = cur + (tot + 4 + 255) / 256;
    if (n >= RE) n = n - (RE - RS);
    return n;
  endfunction

  function automatic bit ring_full(int cur, int bnd);
    int fp;
    fp = (cur <= bnd) ? bnd - cur : (RE - RS) - (cur - bnd);
    return (fp * 256) < 1518;
  endfunction

  task automatic expect_frame(int cur, int len);
    int eff;
    int a;
    int tot;
    eff = (len < 60) ? 60 : len;
    tot = eff + 4;
    a = cur * 256 + 4;
    for (int i = 0; i < eff; i++) begin
      exp_addr.push_back(a);
      exp_data.push_back(i < len ? int'(fb[i]) : 0);
      exp_tag.push_back(i < len ? ((a == RS * 256 && i > 0) ? "R5 wrapped payload" : "R4 payload")
                                : "R6 padding");
      a++;
      if (a == RE * 256) a = RS * 256;
    end
    exp_addr.push_back(cur * 256);
    exp_data.push_back((len > 0 && fb[0][0]) ? 8'h21 : 8'h01);
    exp_tag.push_back("R7 status");
    exp_addr.push_back(cur * 256 + 1);
    exp_data.push_back(next_page(cur, len));
    exp_tag.push_back("R7/R8 next page");
    exp_addr.push_back(cur * 256 + 2);
    exp_data.push_back(tot & 255);
    exp_tag.push_back("R7 length low");
    exp_addr.push_back(cur * 256 + 3);
    exp_data.push_back(tot >> 8);
    exp_tag.push_back("R7 length high");
  endtask

  task automatic fill(int len, bit odd);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    if (len > 0) fb[0][0] = odd;
  endtask

  task automatic set_cur(int v);
    @(negedge clk);
    cur_wr = 1'b1;
    cur_wdata = PG_W'(v);
    @(negedge clk);
    cur_wr = 1'b0;
    chk(int'(cur_pg) == v, "R9 idle load of current page", int'(cur_pg), v);
  endtask

  task automatic run_frame(int len, bit poke);
    int cur;
    bit take;
    int expn;
    cur = int'(cur_pg);
    take = !stopped && !ring_full(cur, int'(bnd_pg));
    expn = take ? next_page(cur, len) : cur;
    if (take) expect_frame(cur, len);
    @(negedge clk);
    frm_start = 1'b1;
    frm_len = LEN_W'(len);
    @(negedge clk);
    frm_start = 1'b0;
    if (take) begin
      int i;
      int t;
      chk(busy == 1'b1, "R1 busy after acceptance", int'(busy), 1);
      i = 0;
      t = 0;
      while (i < len && t < 20000) begin
        cur_wr = poke && (i == 1);
        cur_wdata = PG_W'(RS + 1);
        if (in_rdy && $urandom_range(0, 3) != 0) begin
          byte_valid = 1'b1;
          byte_data = fb[i];
          i++;
        end else begin
          byte_valid = 1'b0;
        end
        @(negedge clk);
        t++;
      end
      byte_valid = 1'b0;
      cur_wr = 1'b0;
      t = 0;
      while (busy && t < 4000) begin
        @(negedge clk);
        t++;
      end
      chk(irq_rx == 1'b1, "R8 irq with page update", int'(irq_rx), 1);
      chk(int'(cur_pg) == expn, poke ? "R9 busy load ignored" : "R8 next page", int'(cur_pg), expn);
      chk(exp_addr.size() == 0, "R4 write count", exp_addr.size(), 0);
      @(negedge clk);
      chk(irq_rx == 1'b0, "R8 irq one cycle", int'(irq_rx), 0);
    end else begin
      repeat (4) begin
        chk(busy == 1'b0, stopped ? "R2 stay idle" : "R3 stay idle", int'(busy), 0);
        @(negedge clk);
      end
      chk(int'(cur_pg) == expn, stopped ? "R2 page kept" : "R3 page kept", int'(cur_pg), expn);
      chk(irq_rx == 1'b0, "R2/R3 no irq", int'(irq_rx), 0);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy reset", int'(busy), 0);
    chk(in_rdy == 1'b0 && mem_we == 1'b0, "R10 outputs reset", int'({in_rdy, mem_we}), 0);
    chk(irq_rx == 1'b0, "R10 irq reset", int'(irq_rx), 0);
    chk(int'(cur_pg) == 0, "R10 page reset", int'(cur_pg), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: both free-space formulas at the 5 and 6 page edges, and equality
    set_cur(8'h42); bnd_pg = 8'h47; fill(1514, 1'b0); run_frame(1514, 1'b0);
    bnd_pg = 8'h42; fill(100, 1'b0); run_frame(100, 1'b0);
    bnd_pg = 8'h48; fill(100, 1'b1); run_frame(100, 1'b0);
    set_cur(8'h4C); bnd_pg = 8'h41; fill(80, 1'b0); run_frame(80, 1'b0);
    bnd_pg = 8'h42; fill(80, 1'b0); run_frame(80, 1'b0);

    // R2: stopped controller
    bnd_pg = 8'h3F;
    set_cur(8'h44);
    stopped = 1'b1; fill(70, 1'b0); run_frame(70, 1'b0);
    stopped = 1'b0;

    // R5/R8: mid-frame wrap from the last page
    set_cur(8'h4F); bnd_pg = 8'h4E; fill(600, 1'b1); run_frame(600, 1'b0);

    // R6 and exact-minimum frames, R9 load while busy
    bnd_pg = 8'(int'(cur_pg) - 1); fill(59, 1'b1); run_frame(59, 1'b0);
    bnd_pg = 8'(int'(cur_pg) - 1); fill(60, 1'b0); run_frame(60, 1'b1);
    bnd_pg = 8'(int'(cur_pg) - 1); fill(1, 1'b1); run_frame(1, 1'b0);

    for (int n = 0; n < 40; n++) begin
      int len;
      int sel;
      sel = $urandom_range(0, 7);
      if (sel == 0) len = $urandom_range(1, 59);
      else if (sel == 1) len = ($urandom_range(0, 1) != 0) ? 60 : 1514;
      else len = $urandom_range(61, 600);
      bnd_pg = (int'(cur_pg) == RS) ? PG_W'(RE - 1) : PG_W'(int'(cur_pg) - 1);
      stopped = ($urandom_range(0, 9) == 0);
      fill(len, 1'($urandom));
      run_frame(len, 1'b0);
    end
    stopped = 1'b0;

    summary();
    $finish;
  end
endmodule